// File: doc/BRIEF.md
# Configurable Parallel Port with Pattern Match

The block is one eight-bit general-purpose parallel port. Every bit can be set on its own as an input or an output, as an inverting or a true path, and with a special option: a sticky "ones catcher" on inputs, or open-drain drive on outputs. Writes to the output data go first to a holding register and then to an output register that drives the pins. Incoming pin values pass through a two-flop synchronizer before polarity, catching and matching are applied.

A pattern unit compares the port value against a programmed reference. Each bit is set to don't-care, any-edge, level or directed-edge by a mask register and a transition register, with a polarity register giving the target level. A rising match sets a sticky pending flag in the command/status register. The interrupt output is that flag gated by an enable bit.

Software reaches all registers over a simple bus: a write strobe, a 3-bit address, write data and a combinational read data output. The addresses are: 0 data, 1 command/status, 2 path polarity, 3 direction, 4 special option, 5 match polarity, 6 match transition, 7 match mask.

Top module: `pport_top`

## Requirements
- R1: After reset, every bit is an input (`pin_oe` = 0), all configuration registers read 0, and `irq` is low.
- R2: A direction bit of 1 makes that bit an output with `pin_oe` high. A direction bit of 0 keeps `pin_oe` low for that bit.
- R3: A path polarity bit of 1 inverts that bit both ways: pin to read data for inputs, and output register to pin for outputs.
- R4: A data write reaches the pins two clock edges after the write edge, going through the holding register and then the output register. Reading address 0 returns the output register for output bits.
- R5: A change on `pin_in` appears on a read of address 0 after two clock edges, and not after one.
- R6: An output bit with its special bit set is open-drain: `pin_out` is 0 for that bit, and `pin_oe` is high only while the driven level is 0.
- R7: An input bit with its special bit set is a ones catcher: it reads 1 after a rising internal value and holds 1 until a data write with 0 in that bit.
- R8: Per-bit match code {mask, transition}: 00 is don't-care; 01 is any change; 10 is value equal to the match polarity bit; 11 is a change toward the match polarity bit.
- R9: The port matches when every bit that is not don't-care matches and at least one bit is not don't-care. The live match state reads at status bit 6.
- R10: Status bit 7 (pending) is set when the match goes from false to true. It stays set until a write to address 1 with bit 7 = 1.
- R11: `irq` is high exactly when pending is set and the enable bit (status bit 0) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle. Input bits never drive their pads. Open-drain bits never drive a high level. Caught ones and the pending flag only leave the 1 state through the bus. Pending only rises together with a fresh match. The bench scenarios show the rest: each mask/transition code on a match, the two-edge synchronizer and double-buffer latencies, polarity inversion in both directions, and the interrupt gating.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_DATA = 3'd0,
        A_CSR  = 3'd1,
        A_DPOL = 3'd2,
        A_DIR  = 3'd3,
        A_SPEC = 3'd4,
        A_PPOL = 3'd5,
        A_PTRN = 3'd6,
        A_PMSK = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/pport_match.sv
module pport_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_v,
    input  logic [W-1:0] prev_v,
    input  logic [W-1:0] tgt_pol,
    input  logic [W-1:0] msk,
    input  logic [W-1:0] trn,
    output logic         hit
);
    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case ({msk[i], trn[i]})
                2'b00:   bit_ok[i] = 1'b1;
                2'b01:   bit_ok[i] = cur_v[i] ^ prev_v[i];
                2'b10:   bit_ok[i] = (cur_v[i] == tgt_pol[i]);
                default: bit_ok[i] = (cur_v[i] == tgt_pol[i]) && (prev_v[i] != tgt_pol[i]);
            endcase
        end
    end

    assign hit = (|(msk | trn)) && (&bit_ok);
endmodule

// File: rtl/pport_top.sv
module pport_top
    import pport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic          irq
);
    localparam int PEND_BIT  = W - 1;
    localparam int MATCH_BIT = W - 2;
    localparam int IE_BIT    = 0;

    typedef struct packed {
        logic [W-1:0] dpol;
        logic [W-1:0] dir;
        logic [W-1:0] spec;
        logic [W-1:0] ppol;
        logic [W-1:0] ptrn;
        logic [W-1:0] pmsk;
        logic [W-1:0] hold;
        logic [W-1:0] outr;
        logic [W-1:0] catchr;
        logic [W-1:0] prev;
        logic         ie;
        logic         pend;
        logic         match;
    } port_t;

    port_t st_d, st_q;

    logic [W-1:0] sync_v;
    logic [W-1:0] in_val;
    logic [W-1:0] obs_v;
    logic [W-1:0] lvl;
    logic         hit;
    logic         wr_data;
    logic         wr_csr;

    pport_sync #(.W(W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (sync_v)
    );

    assign in_val  = sync_v ^ st_q.dpol;
    assign obs_v   = (st_q.dir & st_q.outr) | (~st_q.dir & in_val);
    assign wr_data = wr_en && (addr == A_DATA);
    assign wr_csr  = wr_en && (addr == A_CSR);

    pport_match #(.W(W)) u_match (
        .cur_v  (obs_v),
        .prev_v (st_q.prev),
        .tgt_pol(st_q.ppol),
        .msk    (st_q.pmsk),
        .trn    (st_q.ptrn),
        .hit    (hit)
    );

    always_comb begin
        logic [W-1:0] keep;
        logic [W-1:0] rise;
        st_d      = st_q;
        st_d.outr = st_q.hold;
        st_d.prev = obs_v;
        keep      = wr_data ? wdata : '1;
        rise      = in_val & ~st_q.prev;
        st_d.catchr = ((st_q.catchr & keep) | rise) & st_q.spec & ~st_q.dir;
        st_d.match  = hit;
        st_d.pend   = (st_q.pend & ~(wr_csr & wdata[PEND_BIT])) | (hit & ~st_q.match);
        if (wr_en) begin
            unique case (addr)
                A_DATA: st_d.hold = wdata;
                A_CSR:  st_d.ie   = wdata[IE_BIT];
                A_DPOL: st_d.dpol = wdata;
                A_DIR:  st_d.dir  = wdata;
                A_SPEC: st_d.spec = wdata;
                A_PPOL: st_d.ppol = wdata;
                A_PTRN: st_d.ptrn = wdata;
                default: st_d.pmsk = wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_DATA: rdata = (st_q.dir & st_q.outr) |
                            (~st_q.dir & ((st_q.spec & st_q.catchr) | (~st_q.spec & in_val)));
            A_CSR: begin
                rdata[IE_BIT]    = st_q.ie;
                rdata[MATCH_BIT] = st_q.match;
                rdata[PEND_BIT]  = st_q.pend;
            end
            A_DPOL: rdata = st_q.dpol;
            A_DIR:  rdata = st_q.dir;
            A_SPEC: rdata = st_q.spec;
            A_PPOL: rdata = st_q.ppol;
            A_PTRN: rdata = st_q.ptrn;
            default: rdata = st_q.pmsk;
        endcase
    end

    assign lvl     = st_q.outr ^ st_q.dpol;
    assign pin_oe  = st_q.dir & (~st_q.spec | ~lvl);
    assign pin_out = lvl & st_q.dir & ~st_q.spec;
    assign irq     = st_q.pend & st_q.ie;

    // R2
    input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~st_q.dir) == '0);

    // R6
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & pin_oe & st_q.spec) == '0);

    // R7
    catch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((st_q.catchr & $past(st_q.catchr)) == $past(st_q.catchr)));

    // R10
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !(wr_csr && wdata[PEND_BIT])) |=> st_q.pend);

    // R10
    pend_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> (st_q.match && !$past(st_q.match)));
endmodule

// File: tb/tb_pport_top.sv
module tb_pport_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pport_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {mask, transition, polarity, pin_before, pin_after, expected pending}
    localparam logic [40:0] VEC [11] = '{
        {8'h0F, 8'h00, 8'h05, 8'h00, 8'h05, 1'b1},
        {8'h0F, 8'h00, 8'h05, 8'h00, 8'hF5, 1'b1},
        {8'h0F, 8'h00, 8'h05, 8'h00, 8'h04, 1'b0},
        {8'h01, 8'h01, 8'h01, 8'h00, 8'h01, 1'b1},
        {8'h01, 8'h01, 8'h01, 8'h01, 8'h00, 1'b0},
        {8'h00, 8'h08, 8'h00, 8'h00, 8'h08, 1'b1},
        {8'h00, 8'h08, 8'h00, 8'h08, 8'h00, 1'b1},
        {8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0},
        {8'h03, 8'h01, 8'h03, 8'h02, 8'h03, 1'b1},
        {8'h03, 8'h01, 8'h03, 8'h00, 8'h01, 1'b0},
        {8'h03, 8'h01, 8'h03, 8'h00, 8'h03, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(3'd3, v); chk("R1 dir", v, 8'h00);
        rd(3'd1, v); chk("R1 csr", v, 8'h00);

        // R5 synchronizer latency
        pin_in = 8'hA5;
        wait_n(1); rd(3'd0, v); chk("R5 one edge", v, 8'h00);
        wait_n(1); rd(3'd0, v); chk("R5 two edges", v, 8'hA5);

        // R3 input inversion
        wr(3'd2, 8'h0F);
        rd(3'd0, v); chk("R3 input invert", v, 8'hAA);
        wr(3'd2, 8'h00);

        // R2 / R4 output path and double buffering
        wr(3'd3, 8'hFF);
        chk("R2 oe", pin_oe, 8'hFF);
        wr(3'd0, 8'h3C);
        chk("R4 one edge", pin_out, 8'h00);
        wait_n(1);
        chk("R4 two edges", pin_out, 8'h3C);
        rd(3'd0, v); chk("R4 readback", v, 8'h3C);
        wr(3'd2, 8'h01);
        chk("R3 output invert", pin_out, 8'h3D);
        wr(3'd2, 8'h00);

        // R6 open drain on bits 0,1
        wr(3'd4, 8'h03);
        chk("R6 oe low data", pin_oe, 8'hFF);
        chk("R6 out low data", pin_out, 8'h3C);
        wr(3'd0, 8'h3F);
        wait_n(1);
        chk("R6 oe released", pin_oe, 8'hFC);
        chk("R6 out", pin_out, 8'h3C);

        // R7 ones catcher on bit 0
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h01);
        pin_in = 8'h00;
        wait_n(4);
        wr(3'd0, 8'h00);
        rd(3'd0, v); chk("R7 cleared", v, 8'h00);
        pin_in = 8'h01; wait_n(4);
        pin_in = 8'h00; wait_n(4);
        rd(3'd0, v); chk("R7 caught", v, 8'h01);
        wr(3'd0, 8'h01);
        rd(3'd0, v); chk("R7 held on write 1", v, 8'h01);
        wr(3'd0, 8'hFE);
        rd(3'd0, v); chk("R7 clear on write 0", v, 8'h00);
        wr(3'd4, 8'h00);

        // R8 / R9 / R10 pattern table
        for (int i = 0; i < 11; i++) begin
            pin_in = VEC[i][16:9];
            wait_n(4);
            wr(3'd7, VEC[i][40:33]);
            wr(3'd6, VEC[i][32:25]);
            wr(3'd5, VEC[i][24:17]);
            wait_n(4);
            wr(3'd1, 8'h80);
            rd(3'd1, v); chk("R10 cleared", {7'd0, v[7]}, 8'h00);
            pin_in = VEC[i][8:1];
            wait_n(5);
            rd(3'd1, v); chk("R8 R9 R10 vector", {7'd0, v[7]}, {7'd0, VEC[i][0]});
        end

        // R9 live match bit on level compare
        wr(3'd7, 8'h0F); wr(3'd6, 8'h00); wr(3'd5, 8'h05);
        pin_in = 8'hF5; wait_n(4);
        rd(3'd1, v); chk("R9 match on", {7'd0, v[6]}, 8'h01);
        pin_in = 8'h04; wait_n(4);
        rd(3'd1, v); chk("R9 match off", {7'd0, v[6]}, 8'h00);

        // R11 interrupt gating
        wr(3'd1, 8'h81);
        chk("R11 no pend", {7'd0, irq}, 8'h00);
        pin_in = 8'h05; wait_n(5);
        chk("R11 irq on", {7'd0, irq}, 8'h01);
        wr(3'd1, 8'h00);
        chk("R11 irq masked", {7'd0, irq}, 8'h00);
        rd(3'd1, v); chk("R10 still pending", {7'd0, v[7]}, 8'h01);
        wr(3'd1, 8'h81);
        chk("R11 irq cleared", {7'd0, irq}, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule